// File: doc/BRIEF.md
# Watchdog Register Unlock Gate

This block is the register-access front end of a two-stage watchdog timer. It decodes bus writes into a 16-byte register window. A write reaches the protected registers only after a two-write key sequence has been sent to the control offset. When a write is let through, the block passes the new stage-1 or stage-2 preload value to the timer core, sends it keep-alive pings, or clears the sticky "last reset came from the watchdog" flag. Reads return that flag.

The key sequence has two writes to offset 0xC: first the value 0x80, then the value 0x86. After that, exactly one further write is accepted. The gate then closes again, whatever that write was. All timer outputs are single-cycle strobes. They are registered and appear in the cycle after the bus write. The timer core raises `wdt_reset_seen` when its second stage expires, and that input sets the flag. The bus is a plain one-beat register port and has no back-pressure: every write and read completes in the cycle it is presented.

Top module: `wdt_unlock_gate`

## Requirements
- R1: A write whose value is 0x80 to offset 0xC arms the gate from any state, at any access size. The value is the write data zero-extended from its access width: size code 0 = byte (bits 7:0), 1 = 16-bit (bits 15:0), 2 and 3 = 32-bit.
- R2: A write of value 0x86 to offset 0xC opens the gate only when the gate is armed. In any other state it has no unlocking effect.
- R3: While the gate is closed or armed, every other write has no effect and leaves the state unchanged. While the gate is open, the next write that is not 0x80 is consumed and closes the gate, whatever its address and size.
- R4: With the gate open, a 32-bit write (size 2) to offset 0x0 pulses `pre1_load`, and one to offset 0x4 pulses `pre2_load`. `preload_value` carries the low 20 bits of the data in the same cycle.
- R5: With the gate open, a 16-bit write to offset 0xC with bit 8 set pulses `keepalive`.
- R6: With the gate open, a 16-bit write to offset 0xC with bit 9 or bit 12 set clears the reboot flag. `wdt_reset_seen` sets the flag. If both happen in the same cycle, the set wins.
- R7: A 16-bit read of offset 0xC returns 0x1200 while the flag is set and 0 otherwise. Every other read, and `rdata` while no read is presented, is 0.
- R8: A consumed write of the wrong size, or to an undecoded offset, produces no strobe and does not touch the flag.
- R9: After reset the gate is closed, all strobes are low and the flag is clear.
- R10: Every strobe lasts one cycle and appears in the cycle after the write that caused it. At most one strobe is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write request this cycle |
| rd_en | input | 1 | Read request this cycle |
| addr | input | 4 | Byte offset in the register window |
| size | input | 2 | Access size: 0 byte, 1 16-bit, 2 32-bit |
| wdata | input | 32 | Write data, low-lane aligned |
| rdata | output | 32 | Read data, combinational |
| wdt_reset_seen | input | 1 | Timer core: last reset was a watchdog reset |
| keepalive | output | 1 | Restart-stage-1 strobe to the timer core |
| pre1_load | output | 1 | Stage-1 preload load strobe |
| pre2_load | output | 1 | Stage-2 preload load strobe |
| preload_value | output | 20 | Preload value qualified by the load strobes |

## Verification
The gate state cannot be seen directly at the ports. A wrong state shows up one cycle after the next protected write. A gate that is wrongly open produces a strobe that should not appear. A gate that is wrongly closed loses a strobe that was expected. A gate that stays open after a consumed write lets a second protected write through. The bench therefore follows every unlock-and-write pair with a probe write whose strobe must be absent. A fault in the flag shows on the very next 16-bit read of offset 0xC.

// File: rtl/wdt_gate_pkg.sv
package wdt_gate_pkg;
  typedef enum logic [1:0] {
    LK_CLOSED = 2'd0,
    LK_ARMED  = 2'd1,
    LK_OPEN   = 2'd2
  } lock_st_t;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

  localparam logic [3:0] OFS_PRE1 = 4'h0;
  localparam logic [3:0] OFS_PRE2 = 4'h4;
  localparam logic [3:0] OFS_CTRL = 4'hC;

  localparam logic [31:0] KEY_ARM  = 32'h0000_0080;
  localparam logic [31:0] KEY_OPEN = 32'h0000_0086;

  localparam int BIT_PING  = 8;
  localparam int BIT_CLR_A = 9;
  localparam int BIT_CLR_B = 12;

  localparam logic [31:0] FLAG_READ = 32'h0000_1200;

  function automatic logic [31:0] lane_value(input logic [1:0] sz, input logic [31:0] d);
    case (sz)
      SZ_BYTE: lane_value = {24'd0, d[7:0]};
      SZ_HALF: lane_value = {16'd0, d[15:0]};
      default: lane_value = d;
    endcase
  endfunction
endpackage

// File: rtl/wdt_lock_fsm.sv
module wdt_lock_fsm
  import wdt_gate_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr_en,
  input  logic     key_arm,
  input  logic     key_open,
  output lock_st_t state,
  output logic     consume
);
  lock_st_t nxt;

  always_comb begin
    nxt     = state;
    consume = 1'b0;
    if (wr_en) begin
      if (key_arm) begin
        nxt = LK_ARMED;
      end else if (key_open && state == LK_ARMED) begin
        nxt = LK_OPEN;
      end else if (state == LK_OPEN) begin
        nxt     = LK_CLOSED;
        consume = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= LK_CLOSED;
    else        state <= nxt;
  end

  // R1: the arm key always arms
  a_r1_arm_any_state: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && key_arm |=> state == LK_ARMED);
  // R2: the open key outside the armed state never opens
  a_r2_open_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && key_open && !key_arm && state != LK_ARMED |=> state != LK_OPEN);
  // R3: an open gate closes after one non-arm write
  a_r3_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !key_arm && state == LK_OPEN |=> state == LK_CLOSED);
  // R3: a closed gate stays closed on a non-key write
  a_r3_closed_holds: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !key_arm && !key_open && state == LK_CLOSED |=> state == LK_CLOSED);
endmodule

// File: rtl/wdt_action_decode.sv
module wdt_action_decode
  import wdt_gate_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 32,
  parameter int PRELOAD_W = 20
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 consume,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [1:0]           size,
  input  logic [DATA_W-1:0]    value,
  output logic                 ping,
  output logic                 ld1,
  output logic                 ld2,
  output logic [PRELOAD_W-1:0] preload,
  output logic                 clr_req
);
  logic is_word, is_half, at_ctrl;

  always_comb begin
    is_word = (size == SZ_WORD);
    is_half = (size == SZ_HALF);
    at_ctrl = (addr == ADDR_W'(OFS_CTRL));
    clr_req = consume && is_half && at_ctrl && (value[BIT_CLR_A] || value[BIT_CLR_B]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ping    <= 1'b0;
      ld1     <= 1'b0;
      ld2     <= 1'b0;
      preload <= '0;
    end else begin
      ping <= consume && is_half && at_ctrl && value[BIT_PING];
      ld1  <= consume && is_word && (addr == ADDR_W'(OFS_PRE1));
      ld2  <= consume && is_word && (addr == ADDR_W'(OFS_PRE2));
      if (consume && is_word) preload <= value[PRELOAD_W-1:0];
    end
  end

  // R10: at most one strobe at a time
  a_r10_strobe_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ping, ld1, ld2}));
  // R8: a consumed byte write never strobes
  a_r8_byte_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
    consume && size == SZ_BYTE |=> !ping && !ld1 && !ld2);
endmodule

// File: rtl/wdt_reboot_flag.sv
module wdt_reboot_flag
  import wdt_gate_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_i,
  input  logic              clr_i,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  output logic [DATA_W-1:0] rdata
);
  logic flag;

  always_ff @(posedge clk) begin
    if (!rst_n)     flag <= 1'b0;
    else if (set_i) flag <= 1'b1;
    else if (clr_i) flag <= 1'b0;
  end

  always_comb begin
    rdata = '0;
    if (rd_en && size == SZ_HALF && addr == ADDR_W'(OFS_CTRL) && flag)
      rdata = DATA_W'(FLAG_READ);
  end

  // R6: set wins over a clear in the same cycle
  a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag);
  // R7: no read, no data
  a_r7_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> rdata == '0);
endmodule

// File: rtl/wdt_unlock_gate.sv
module wdt_unlock_gate
  import wdt_gate_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 32,
  parameter int PRELOAD_W = 20
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [1:0]           size,
  input  logic [DATA_W-1:0]    wdata,
  output logic [DATA_W-1:0]    rdata,
  input  logic                 wdt_reset_seen,
  output logic                 keepalive,
  output logic                 pre1_load,
  output logic                 pre2_load,
  output logic [PRELOAD_W-1:0] preload_value
);
  logic [31:0] wval;
  logic        key_arm, key_open, consume, clr_req;
  lock_st_t    lk_state;

  always_comb begin
    wval     = lane_value(size, 32'(wdata));
    key_arm  = (addr == ADDR_W'(OFS_CTRL)) && (wval == KEY_ARM);
    key_open = (addr == ADDR_W'(OFS_CTRL)) && (wval == KEY_OPEN);
  end

  wdt_lock_fsm u_lock (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .key_arm  (key_arm),
    .key_open (key_open),
    .state    (lk_state),
    .consume  (consume)
  );

  wdt_action_decode #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .PRELOAD_W (PRELOAD_W)
  ) u_act (
    .clk     (clk),
    .rst_n   (rst_n),
    .consume (consume),
    .addr    (addr),
    .size    (size),
    .value   (DATA_W'(wval)),
    .ping    (keepalive),
    .ld1     (pre1_load),
    .ld2     (pre2_load),
    .preload (preload_value),
    .clr_req (clr_req)
  );

  wdt_reboot_flag #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_flag (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (wdt_reset_seen),
    .clr_i (clr_req),
    .rd_en (rd_en),
    .addr  (addr),
    .size  (size),
    .rdata (rdata)
  );

  // R10: strobes last a single cycle
  a_r10_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    keepalive || pre1_load || pre2_load |=> !keepalive && !pre1_load && !pre2_load);
  // R3: a strobe only follows a write made while the gate was open
  a_r3_strobe_needs_open: assert property (@(posedge clk) disable iff (!rst_n)
    keepalive || pre1_load || pre2_load |-> $past(wr_en) && $past(lk_state == LK_OPEN));
endmodule

// File: tb/wdt_unlock_gate_tb.sv
module wdt_unlock_gate_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [1:0]  size = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        wdt_reset_seen = 1'b0;
  logic        keepalive, pre1_load, pre2_load;
  logic [19:0] preload_value;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  wdt_unlock_gate u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .size(size), .wdata(wdata), .rdata(rdata), .wdt_reset_seen(wdt_reset_seen),
    .keepalive(keepalive), .pre1_load(pre1_load), .pre2_load(pre2_load),
    .preload_value(preload_value)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one-cycle write; returns at the negedge where its strobes are visible
  task automatic wr(input logic [3:0] a, input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; size = s; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic unlock();
    wr(4'hC, 2'd0, 32'h80);
    wr(4'hC, 2'd0, 32'h86);
  endtask

  task automatic rd_chk(input string tag, input logic [3:0] a, input logic [1:0] s,
                        input logic [31:0] exp);
    @(negedge clk);
    rd_en = 1'b1; addr = a; size = s;
    #1 check(tag, rdata, exp);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic strobes(input string tag, input logic k, input logic l1, input logic l2);
    check(tag, {29'd0, keepalive, pre1_load, pre2_load}, {29'd0, k, l1, l2});
  endtask

  task automatic set_flag();
    @(negedge clk); wdt_reset_seen = 1'b1;
    @(negedge clk); wdt_reset_seen = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    strobes("R9 strobes in reset", 1'b0, 1'b0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    strobes("R9 strobes after reset", 1'b0, 1'b0, 1'b0);
    rd_chk("R9 flag clear after reset", 4'hC, 2'd1, 32'h0);

    // R3 R4 R5 R8: sweep every offset and size through an open gate
    for (int a = 0; a < 16; a++) begin
      for (int s = 0; s < 4; s++) begin
        logic [31:0] d;
        logic ek, e1, e2;
        d  = 32'h5A3C_1100 + 32'(a);
        ek = (a == 12) && (s == 1);
        e1 = (a == 0) && (s >= 2 ? (s == 2) : 1'b0);
        e2 = (a == 4) && (s == 2);
        unlock();
        wr(4'(a), 2'(s), d);
        strobes($sformatf("R4 R5 R8 sweep a=%0d s=%0d", a, s), ek, e1, e2);
        if (e1 || e2) check("R4 preload mask", {12'd0, preload_value}, d & 32'hFFFFF);
        wr(4'h0, 2'd2, 32'h12345);
        strobes($sformatf("R3 consumed a=%0d s=%0d", a, s), 1'b0, 1'b0, 1'b0);
      end
    end

    // R10 strobe single cycle
    unlock();
    wr(4'h4, 2'd2, 32'hFFF0_0ABC);
    strobes("R4 stage2 load", 1'b0, 1'b0, 1'b1);
    check("R4 stage2 value", {12'd0, preload_value}, 32'h00ABC);
    @(negedge clk);
    strobes("R10 strobe dropped", 1'b0, 1'b0, 1'b0);

    // R1 arm at 16- and 32-bit, repeated arm
    wr(4'hC, 2'd2, 32'h80); wr(4'hC, 2'd1, 32'h86); wr(4'h0, 2'd2, 32'h7);
    strobes("R1 word arm", 1'b0, 1'b1, 1'b0);
    wr(4'hC, 2'd1, 32'h80); wr(4'hC, 2'd1, 32'h80); wr(4'hC, 2'd2, 32'h86);
    wr(4'h0, 2'd2, 32'h8);
    strobes("R1 double arm", 1'b0, 1'b1, 1'b0);
    // R1 arm high bits make it not a key at 32-bit
    wr(4'hC, 2'd2, 32'h100_0080); wr(4'hC, 2'd2, 32'h86); wr(4'h0, 2'd2, 32'h9);
    strobes("R1 wide value not key", 1'b0, 1'b0, 1'b0);
    // R1 arm from open state
    unlock(); wr(4'hC, 2'd0, 32'h80); wr(4'hC, 2'd0, 32'h86); wr(4'h4, 2'd2, 32'h1);
    strobes("R1 rearm from open", 1'b0, 1'b0, 1'b1);

    // R2 open key without arm
    wr(4'hC, 2'd0, 32'h86); wr(4'h0, 2'd2, 32'h3);
    strobes("R2 open without arm", 1'b0, 1'b0, 1'b0);
    // R2 open key when already open is consumed
    unlock(); wr(4'hC, 2'd0, 32'h86); wr(4'h0, 2'd2, 32'h3);
    strobes("R2 open key consumed", 1'b0, 1'b0, 1'b0);
    // R3 armed state survives another write
    wr(4'hC, 2'd0, 32'h80); wr(4'h0, 2'd2, 32'h5);
    strobes("R3 armed write ignored", 1'b0, 1'b0, 1'b0);
    wr(4'hC, 2'd0, 32'h86); wr(4'h0, 2'd2, 32'h6);
    strobes("R3 armed held", 1'b0, 1'b1, 1'b0);
    // R3 closed: ping ignored
    wr(4'hC, 2'd1, 32'h1100);
    strobes("R3 closed ping ignored", 1'b0, 1'b0, 1'b0);

    // R6 R7 flag behaviour
    set_flag();
    rd_chk("R7 flag read", 4'hC, 2'd1, 32'h1200);
    rd_chk("R7 byte read zero", 4'hC, 2'd0, 32'h0);
    rd_chk("R7 word read zero", 4'hC, 2'd2, 32'h0);
    rd_chk("R7 other offset zero", 4'h8, 2'd1, 32'h0);
    wr(4'hC, 2'd1, 32'h1300);
    rd_chk("R6 locked clear ignored", 4'hC, 2'd1, 32'h1200);
    unlock(); wr(4'hC, 2'd1, 32'h0100);
    strobes("R5 ping without clear", 1'b1, 1'b0, 1'b0);
    rd_chk("R6 ping keeps flag", 4'hC, 2'd1, 32'h1200);
    unlock(); wr(4'hC, 2'd1, 32'h0200);
    strobes("R6 clear bit9 no ping", 1'b0, 1'b0, 1'b0);
    rd_chk("R6 clear bit9", 4'hC, 2'd1, 32'h0);
    set_flag();
    unlock(); wr(4'hC, 2'd1, 32'h1000);
    rd_chk("R6 clear bit12", 4'hC, 2'd1, 32'h0);
    set_flag();
    unlock(); wr(4'hC, 2'd0, 32'h00);
    rd_chk("R8 byte clear ignored", 4'hC, 2'd1, 32'h1200);
    unlock(); wr(4'h8, 2'd1, 32'h1200);
    rd_chk("R8 other offset clear ignored", 4'hC, 2'd1, 32'h1200);
    unlock();
    @(negedge clk);
    wr_en = 1'b1; addr = 4'hC; size = 2'd1; wdata = 32'h0200; wdt_reset_seen = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; wdt_reset_seen = 1'b0;
    rd_chk("R6 set wins", 4'hC, 2'd1, 32'h1200);

    done = 1;
  end

  initial begin
    for (int i = 0; i < 20000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=done");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule